// File: doc/BRIEF.md
# Shared-Bus Accumulator Datapath

This block is the register and memory datapath of a small accumulator machine. Eight registers and a word-addressed memory sit on one 16-bit bus. A 3-bit source code picks the single driver of the bus in each cycle. Every register that listens to the bus has its own strobes, applied on the rising clock edge. A sequencer outside this block drives the strobes. Because the bus is combinational, one register can drive it while any number of others capture it in the same cycle.

The registers differ in width. The two address registers hold 12 bits. They put zeros in the top four bus bits when they drive, and they keep only the low 12 bits when they load. The input and output character registers hold 8 bits and sit on the low byte of the bus. The input register only drives the bus: it is filled from an external character port. The output register only listens to the bus. The memory always takes its address from the address register, so the memory needs no separate address path.

Top module: `shared_bus_datapath`

## Requirements
- R1: The bus source code `bus_sel` picks the bus driver: 0 = input character register, zero-extended; 1 = address register; 2 = program counter; 3 = data register; 4 = accumulator; 5 = instruction register; 6 = temporary register; 7 = memory.
- R2: When the address register or the program counter drives the bus, bus bits 15..12 are zero.
- R3: When the address register or the program counter loads from the bus, it takes bus bits 11..0 and ignores the rest.
- R4: A register whose load bit is set captures the bus value at the next rising edge. Bits of `reg_ld` are 0 AR, 1 PC, 2 DR, 3 AC, 4 TR, 5 IR, 6 OUTR. A register may load while another register drives the bus in the same cycle.
- R5: AR, PC, DR, AC and TR have clear and increment strobes. Bits of `reg_clr` and `reg_inc` are 0 AR, 1 PC, 2 DR, 3 AC, 4 TR. Clear wins over load, and load wins over increment. Increment wraps to zero at the register's width.
- R6: IR and OUTR load only. OUTR takes bus bits 7..0.
- R7: The input character register captures `in_char` at the edge when `in_ld` is set. It holds its value otherwise.
- R8: When `mem_wr` is set, the memory stores the bus value at the edge. The address is the AR value before that edge, even if AR changes at the same edge.
- R9: With code 7 and `mem_rd` set, the bus carries the memory word at the AR address. With code 7 and `mem_rd` clear, the bus is all zeros.
- R10: Reset (`rst_n` low) clears every register to zero. A register with no strobe set keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 3 | Bus source code |
| reg_ld | input | 7 | Load strobes (AR, PC, DR, AC, TR, IR, OUTR) |
| reg_inc | input | 5 | Increment strobes (AR, PC, DR, AC, TR) |
| reg_clr | input | 5 | Clear strobes (AR, PC, DR, AC, TR) |
| mem_wr | input | 1 | Memory write strobe |
| mem_rd | input | 1 | Memory read enable for bus code 7 |
| in_ld | input | 1 | Capture strobe for the input character |
| in_char | input | 8 | Character from the input device |
| bus_q | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |
| outr_q | output | 8 | Output character register |
| inpr_q | output | 8 | Input character register |

## Verification
The bench targets the width joints between the registers and the bus.

- **Zero-extension on drive.** It counts the accumulator up to all ones and then moves that value into the 12-bit and 8-bit registers. A design that extended with ones, or that skipped truncation, would show set bits above bit 11 on the bus, or a wrong address.
- **Wrap on increment.** It increments every counting register past its top value. A design that carried into a wider register would fail to return to zero.
- **Strobe priority.** It sets clear, load and increment together, then load with increment. A design with the wrong order would keep data or count instead of clearing.
- **Memory write address.** It writes to memory while incrementing the address register in the same cycle, then reads both back. A design that used the updated address, or that drove stale data onto the bus when read was off, would miscompare.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

  // Bus source codes; the numeric values are what the sequencer drives.
  typedef enum logic [2:0] {
    SRC_INPR = 3'd0,
    SRC_AR   = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DR   = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IR   = 3'd5,
    SRC_TR   = 3'd6,
    SRC_MEM  = 3'd7
  } bus_src_e;

  // Strobe bit positions (shared by load, increment and clear vectors).
  localparam int IDX_AR   = 0;
  localparam int IDX_PC   = 1;
  localparam int IDX_DR   = 2;
  localparam int IDX_AC   = 3;
  localparam int IDX_TR   = 4;
  localparam int IDX_IR   = 5;
  localparam int IDX_OUTR = 6;

  localparam int NUM_CNT  = 5;  // registers with clear and increment
  localparam int NUM_LD   = 7;  // registers with a load strobe
  localparam int NUM_SRC  = 8;  // bus sources

endpackage

// File: rtl/sbd_reg.sv
module sbd_reg #(
  parameter int W      = 16,
  parameter bit COUNTS = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         inc,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // Next-state rule: clear over load over increment.
  function automatic logic [W-1:0] next_val(input logic [W-1:0] cur,
                                            input logic [W-1:0] din,
                                            input logic l, input logic i,
                                            input logic c);
    if (COUNTS && c)      return '0;
    else if (l)           return din;
    else if (COUNTS && i) return cur + {{(W-1){1'b0}}, 1'b1};
    else                  return cur;
  endfunction

  logic [W-1:0] q_nx;
  assign q_nx = next_val(q, d, ld, inc, clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nx;
  end

endmodule

// File: rtl/sbd_mem.sv
module sbd_mem #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) words[addr] <= wdata;
  end

  assign rdata = words[addr];

endmodule

// File: rtl/sbd_bus_mux.sv
module sbd_bus_mux
  import sbd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [2:0]                 sel,
  input  logic                       rd_en,
  input  logic [NUM_SRC-1:0][DW-1:0] src,
  output logic [DW-1:0]              y
);

  always_comb begin
    if (sel == SRC_MEM && !rd_en) y = '0;
    else                          y = src[sel];
  end

endmodule

// File: rtl/shared_bus_datapath.sv
module shared_bus_datapath
  import sbd_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int IW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          bus_sel,
  input  logic [NUM_LD-1:0]   reg_ld,
  input  logic [NUM_CNT-1:0]  reg_inc,
  input  logic [NUM_CNT-1:0]  reg_clr,
  input  logic                mem_wr,
  input  logic                mem_rd,
  input  logic                in_ld,
  input  logic [IW-1:0]       in_char,
  output logic [DW-1:0]       bus_q,
  output logic [AW-1:0]       ar_q,
  output logic [AW-1:0]       pc_q,
  output logic [DW-1:0]       dr_q,
  output logic [DW-1:0]       ac_q,
  output logic [DW-1:0]       ir_q,
  output logic [DW-1:0]       tr_q,
  output logic [IW-1:0]       outr_q,
  output logic [IW-1:0]       inpr_q
);

  localparam int PAD_A = DW - AW;
  localparam int PAD_I = DW - IW;

  function automatic logic [DW-1:0] widen_addr(input logic [AW-1:0] a);
    return {{PAD_A{1'b0}}, a};
  endfunction

  function automatic logic [DW-1:0] widen_char(input logic [IW-1:0] c);
    return {{PAD_I{1'b0}}, c};
  endfunction

  // Named internal nets, also observed by the bound checker.
  logic [DW-1:0]              bus_w;
  logic [DW-1:0]              mem_word;
  logic [1:0][AW-1:0]         addr_q;   // 0 = AR, 1 = PC
  logic [2:0][DW-1:0]         data_q;   // 0 = DR, 1 = AC, 2 = TR
  logic [DW-1:0]              ir_r;
  logic [IW-1:0]              outr_r;
  logic [IW-1:0]              inpr_r;
  logic [NUM_SRC-1:0][DW-1:0] src;

  // 12-bit counting registers take the low bus bits.
  for (genvar g = 0; g < 2; g++) begin : g_addr
    sbd_reg #(.W(AW), .COUNTS(1'b1)) u_reg (
      .clk (clk), .rst_n(rst_n),
      .ld  (reg_ld[IDX_AR + g]), .inc(reg_inc[IDX_AR + g]),
      .clr (reg_clr[IDX_AR + g]),
      .d   (bus_w[AW-1:0]), .q(addr_q[g])
    );
  end

  // Full-width counting registers.
  for (genvar g = 0; g < 3; g++) begin : g_data
    sbd_reg #(.W(DW), .COUNTS(1'b1)) u_reg (
      .clk (clk), .rst_n(rst_n),
      .ld  (reg_ld[IDX_DR + g]), .inc(reg_inc[IDX_DR + g]),
      .clr (reg_clr[IDX_DR + g]),
      .d   (bus_w), .q(data_q[g])
    );
  end

  sbd_reg #(.W(DW), .COUNTS(1'b0)) u_ir (
    .clk(clk), .rst_n(rst_n), .ld(reg_ld[IDX_IR]), .inc(1'b0), .clr(1'b0),
    .d(bus_w), .q(ir_r)
  );

  sbd_reg #(.W(IW), .COUNTS(1'b0)) u_outr (
    .clk(clk), .rst_n(rst_n), .ld(reg_ld[IDX_OUTR]), .inc(1'b0), .clr(1'b0),
    .d(bus_w[IW-1:0]), .q(outr_r)
  );

  sbd_reg #(.W(IW), .COUNTS(1'b0)) u_inpr (
    .clk(clk), .rst_n(rst_n), .ld(in_ld), .inc(1'b0), .clr(1'b0),
    .d(in_char), .q(inpr_r)
  );

  sbd_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(mem_wr), .addr(addr_q[0]), .wdata(bus_w), .rdata(mem_word)
  );

  always_comb begin
    src[SRC_INPR] = widen_char(inpr_r);
    src[SRC_AR]   = widen_addr(addr_q[0]);
    src[SRC_PC]   = widen_addr(addr_q[1]);
    src[SRC_DR]   = data_q[0];
    src[SRC_AC]   = data_q[1];
    src[SRC_IR]   = ir_r;
    src[SRC_TR]   = data_q[2];
    src[SRC_MEM]  = mem_word;
  end

  sbd_bus_mux #(.DW(DW)) u_mux (
    .sel(bus_sel), .rd_en(mem_rd), .src(src), .y(bus_w)
  );

  assign bus_q  = bus_w;
  assign ar_q   = addr_q[0];
  assign pc_q   = addr_q[1];
  assign dr_q   = data_q[0];
  assign ac_q   = data_q[1];
  assign tr_q   = data_q[2];
  assign ir_q   = ir_r;
  assign outr_q = outr_r;
  assign inpr_q = inpr_r;

endmodule

// File: rtl/sbd_checker.sv
module sbd_checker #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int IW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    bus_sel,
  input logic          ld_pc,
  input logic          clr_pc,
  input logic          ld_dr,
  input logic          clr_dr,
  input logic          ld_ac,
  input logic          inc_ac,
  input logic          clr_ac,
  input logic          ld_tr,
  input logic          inc_tr,
  input logic          clr_tr,
  input logic          ld_outr,
  input logic          mem_wr,
  input logic          mem_rd,
  input logic          in_ld,
  input logic [IW-1:0] in_char,
  input logic [DW-1:0] bus_q,
  input logic [DW-1:0] mem_word,
  input logic [AW-1:0] ar_q,
  input logic [AW-1:0] pc_q,
  input logic [DW-1:0] dr_q,
  input logic [DW-1:0] ac_q,
  input logic [DW-1:0] tr_q,
  input logic [IW-1:0] outr_q,
  input logic [IW-1:0] inpr_q
);

  p_zext_ar_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel == 3'd1 |-> bus_q == {{(DW-AW){1'b0}}, ar_q});

  p_zext_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel == 3'd2 |-> bus_q[DW-1:AW] == '0);

  p_trunc_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pc && !clr_pc |=> pc_q == $past(bus_q[AW-1:0]));

  p_load_dr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_dr && !clr_dr |=> dr_q == $past(bus_q));

  p_clear_ac_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ac |=> ac_q == '0);

  p_count_ac_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inc_ac && !ld_ac && !clr_ac |=> ac_q == DW'($past(ac_q) + 1'b1));

  p_outr_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_outr |=> outr_q == $past(bus_q[IW-1:0]));

  p_inpr_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ld |=> inpr_q == $past(in_char));

  p_mem_rdback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_wr) && mem_rd && bus_sel == 3'd7 && $stable(ar_q)
      |-> bus_q == $past(bus_q));

  p_mem_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel == 3'd7 && mem_rd |-> bus_q == mem_word);

  p_mem_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel == 3'd7 && !mem_rd |-> bus_q == '0);

  p_hold_tr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_tr && !inc_tr && !clr_tr |=> $stable(tr_q));

endmodule

bind shared_bus_datapath sbd_checker #(.AW(AW), .DW(DW), .IW(IW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_sel (bus_sel),
  .ld_pc   (reg_ld[1]),
  .clr_pc  (reg_clr[1]),
  .ld_dr   (reg_ld[2]),
  .clr_dr  (reg_clr[2]),
  .ld_ac   (reg_ld[3]),
  .inc_ac  (reg_inc[3]),
  .clr_ac  (reg_clr[3]),
  .ld_tr   (reg_ld[4]),
  .inc_tr  (reg_inc[4]),
  .clr_tr  (reg_clr[4]),
  .ld_outr (reg_ld[6]),
  .mem_wr  (mem_wr),
  .mem_rd  (mem_rd),
  .in_ld   (in_ld),
  .in_char (in_char),
  .bus_q   (bus_q),
  .mem_word(mem_word),
  .ar_q    (ar_q),
  .pc_q    (pc_q),
  .dr_q    (dr_q),
  .ac_q    (ac_q),
  .tr_q    (tr_q),
  .outr_q  (outr_q),
  .inpr_q  (inpr_q)
);

// File: tb/sim_shared_bus_datapath.sv
`timescale 1ns/1ps
module sim_shared_bus_datapath;

  localparam logic [6:0] L_AR = 7'h01, L_PC = 7'h02, L_DR = 7'h04,
                         L_AC = 7'h08, L_TR = 7'h10, L_IR = 7'h20,
                         L_OUTR = 7'h40;
  localparam logic [4:0] C_AR = 5'h01, C_PC = 5'h02, C_DR = 5'h04,
                         C_AC = 5'h08, C_TR = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  sel = '0;
  logic [6:0]  ld = '0;
  logic [4:0]  inc = '0;
  logic [4:0]  clr = '0;
  logic        wr = 1'b0, rd = 1'b0, il = 1'b0;
  logic [7:0]  ch = '0;

  logic [15:0] bus_q, dr_q, ac_q, ir_q, tr_q;
  logic [11:0] ar_q, pc_q;
  logic [7:0]  outr_q, inpr_q;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  shared_bus_datapath u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .reg_ld(ld), .reg_inc(inc),
    .reg_clr(clr), .mem_wr(wr), .mem_rd(rd), .in_ld(il), .in_char(ch),
    .bus_q(bus_q), .ar_q(ar_q), .pc_q(pc_q), .dr_q(dr_q), .ac_q(ac_q),
    .ir_q(ir_q), .tr_q(tr_q), .outr_q(outr_q), .inpr_q(inpr_q)
  );

  task automatic check(input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle's inputs mid-cycle and let the bus settle.
  task automatic drv(input logic [2:0] s, input logic [6:0] l,
                     input logic [4:0] i, input logic [4:0] c,
                     input logic w, input logic r, input logic inl,
                     input logic [7:0] chv);
    @(negedge clk);
    sel = s; ld = l; inc = i; clr = c; wr = w; rd = r; il = inl; ch = chv;
    #1;
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic set_ar(input logic [7:0] a);
    drv(3'd0, 7'h00, 5'h00, 5'h00, 1'b0, 1'b0, 1'b1, a); tick;
    drv(3'd0, L_AR, 5'h00, 5'h00, 1'b0, 1'b0, 1'b0, 8'h00); tick;
  endtask

  function automatic logic [15:0] mem_exp(input int a);
    return (a % 2 == 0) ? 16'hFFFF : 16'(a);
  endfunction

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R10: reset state
    check("R10 ar", {4'h0, ar_q}, 16'h0);
    check("R10 pc", {4'h0, pc_q}, 16'h0);
    check("R10 dr", dr_q, 16'h0);
    check("R10 ac", ac_q, 16'h0);
    check("R10 ir", ir_q, 16'h0);
    check("R10 tr", tr_q, 16'h0);
    check("R10 outr", {8'h0, outr_q}, 16'h0);
    check("R10 inpr", {8'h0, inpr_q}, 16'h0);

    // Sweep every input character through the bus into the listeners.
    for (int v = 0; v < 256; v++) begin
      drv(3'd0, 7'h00, 5'h00, 5'h00, 1'b0, 1'b0, 1'b1, 8'(v)); tick;
      check("R7 inpr capture", {8'h0, inpr_q}, 16'(v));
      drv(3'd0, L_AR | L_PC | L_DR | L_TR | L_IR | L_OUTR, 5'h00, 5'h00,
          1'b0, 1'b0, 1'b0, 8'(v) ^ 8'hFF);
      check("R1 code0 inpr", bus_q, 16'(v));
      tick;
      check("R4 ar", {4'h0, ar_q}, 16'(v));
      check("R4 dr", dr_q, 16'(v));
      check("R6 ir", ir_q, 16'(v));
      check("R6 outr", {8'h0, outr_q}, 16'(v));
      check("R7 inpr hold", {8'h0, inpr_q}, 16'(v));
    end

    // Count the accumulator to all ones.
    drv(3'd0, 7'h00, 5'h00, C_AC, 1'b0, 1'b0, 1'b0, 8'h00); tick;
    check("R5 ac clear", ac_q, 16'h0);
    for (int k = 0; k < 65535; k++) begin
      drv(3'd0, 7'h00, C_AC, 5'h00, 1'b0, 1'b0, 1'b0, 8'h00); tick;
    end
    check("R5 ac count", ac_q, 16'hFFFF);

    drv(3'd4, L_AR | L_PC | L_DR | L_TR | L_IR | L_OUTR, 5'h00, 5'h00,
        1'b0, 1'b0, 1'b0, 8'h00);
    check("R1 code4 ac", bus_q, 16'hFFFF);
    tick;
    check("R3 ar trunc", {4'h0, ar_q}, 16'h0FFF);
    check("R3 pc trunc", {4'h0, pc_q}, 16'h0FFF);
    check("R4 dr full", dr_q, 16'hFFFF);
    check("R4 tr full", tr_q, 16'hFFFF);
    check("R6 ir full", ir_q, 16'hFFFF);
    check("R6 outr low", {8'h0, outr_q}, 16'h00FF);

    drv(3'd1, 7'h00, 5'h00, 5'h00, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R2 ar zext", bus_q, 16'h0FFF);
    drv(3'd2, 7'h00, 5'h00, 5'h00, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R2 pc zext", bus_q, 16'h0FFF);
    drv(3'd3, 7'h00, 5'h00, 5'h00, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R1 code3 dr", bus_q, 16'hFFFF);
    drv(3'd5, 7'h00, 5'h00, 5'h00, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R1 code5 ir", bus_q, 16'hFFFF);
    drv(3'd6, 7'h00, 5'h00, 5'h00, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R1 code6 tr", bus_q, 16'hFFFF);

    // Store at the top address, then wrap every counter.
    drv(3'd4, 7'h00, 5'h00, 5'h00, 1'b1, 1'b0, 1'b0, 8'h00); tick;
    drv(3'd0, 7'h00, C_AR | C_PC | C_DR | C_AC | C_TR, 5'h00,
        1'b0, 1'b0, 1'b0, 8'h00); tick;
    check("R5 ar wrap", {4'h0, ar_q}, 16'h0);
    check("R5 pc wrap", {4'h0, pc_q}, 16'h0);
    check("R5 dr wrap", dr_q, 16'h0);
    check("R5 ac wrap", ac_q, 16'h0);
    check("R5 tr wrap", tr_q, 16'h0);

    // Strobe priority on the accumulator.
    drv(3'd5, L_DR, 5'h00, 5'h00, 1'b0, 1'b0, 1'b0, 8'h00); tick;
    check("R4 dr from ir", dr_q, 16'hFFFF);
    drv(3'd3, L_AC, C_AC, C_AC, 1'b0, 1'b0, 1'b0, 8'h00); tick;
    check("R5 clear beats load", ac_q, 16'h0);
    drv(3'd3, L_AC, C_AC, 5'h00, 1'b0, 1'b0, 1'b0, 8'h00); tick;
    check("R5 load beats inc", ac_q, 16'hFFFF);
    drv(3'd0, 7'h00, C_AC, 5'h00, 1'b0, 1'b0, 1'b0, 8'h00); tick;
    drv(3'd0, 7'h00, C_AC, 5'h00, 1'b0, 1'b0, 1'b0, 8'h00); tick;
    check("R5 inc after wrap", ac_q, 16'h1);

    // No strobes: everything holds.
    drv(3'd3, 7'h00, 5'h00, 5'h00, 1'b0, 1'b0, 1'b0, 8'h3C); tick;
    check("R10 hold dr", dr_q, 16'hFFFF);
    check("R10 hold ac", ac_q, 16'h1);
    check("R10 hold ir", ir_q, 16'hFFFF);
    check("R10 hold outr", {8'h0, outr_q}, 16'h00FF);
    check("R10 hold inpr", {8'h0, inpr_q}, 16'h00FF);
    check("R10 hold tr", tr_q, 16'h0);

    // Fill 64 words: even from DR (all ones), odd from the input char.
    for (int a = 0; a < 64; a++) begin
      set_ar(8'(a));
      drv((a % 2 == 0) ? 3'd3 : 3'd0, 7'h00, 5'h00, 5'h00, 1'b1, 1'b0,
          1'b0, 8'h00);
      tick;
    end
    // Write with a same-edge address increment.
    set_ar(8'd100);
    drv(3'd3, 7'h00, C_AR, 5'h00, 1'b1, 1'b0, 1'b0, 8'h00); tick;
    check("R8 ar advanced", {4'h0, ar_q}, 16'd101);

    for (int a = 0; a < 64; a++) begin
      set_ar(8'(a));
      drv(3'd7, 7'h00, 5'h00, 5'h00, 1'b0, 1'b0, 1'b0, 8'h00);
      check("R9 no read zero", bus_q, 16'h0);
      drv(3'd7, L_AC, 5'h00, 5'h00, 1'b0, 1'b1, 1'b0, 8'h00);
      check("R9 read word", bus_q, mem_exp(a));
      tick;
      check("R8 ac from mem", ac_q, mem_exp(a));
    end
    set_ar(8'd100);
    drv(3'd7, 7'h00, 5'h00, 5'h00, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R8 old address used", bus_q, 16'hFFFF);
    drv(3'd3, L_AR, 5'h00, 5'h00, 1'b0, 1'b0, 1'b0, 8'h00); tick;
    drv(3'd7, 7'h00, 5'h00, 5'h00, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R8 top address", bus_q, 16'hFFFF);
    drv(3'd0, 7'h00, 5'h00, 5'h00, 1'b0, 1'b0, 1'b0, 8'h00); tick;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule